// File: doc/BRIEF.md
# Driver Status Word and Open-Load Diagnosis

This block composes the 16-bit status word that a serial host reads back from a six-output power switch driver. It takes the state of every switch, the result of every open-load comparator, the diagnosis enable, both inhibit sources and the chip-level fault flags. From these it forms the word combinationally. Each per-output bit has two meanings. When the switch is on, the bit reports that it is on. When the switch is off and diagnosis is running, the bit reports the open-load comparator. A thermal shutdown overrides the whole word.

The block also drives one enable per output for the analog open-load test current. That enable is high only for outputs that are actually under test. A two-state machine captures the live word at the start of each serial frame and holds it while the frame is shifted out. Capture happens in state `SNAP_IDLE` on `frame_start`, with the transition IDLE->HOLD. Release happens in state `SNAP_HOLD` on `frame_end`, with the transition HOLD->IDLE. Any other input leaves the state unchanged.

Top module: `drv_diag_status`

## Requirements
- R1: The word carries the temperature prewarning at bit 0, the short-circuit flag at bit 13 and the supply-fail flag at bit 15.
- R2: Output i (0..5, in the order low-side 1, high-side 1, low-side 2, high-side 2, low-side 3, high-side 3) maps to status bit i+1, and that bit reads 1 while the output is switched on.
- R3: Diagnosis is active when `ol_en_n` is 0 and `sw_run` is 1; an output that is off then reports its comparator input at its status bit.
- R4: With `ol_en_n` at 1, an output that is off reads 0 whatever its comparator says.
- R5: With `sw_run` at 0, diagnosis is off for all outputs: off outputs read 0 and no test current is enabled.
- R6: Bit 14 reads 1 whenever `sw_run` or `hw_run` is 0. The hardware inhibit does not stop diagnosis.
- R7: While `thermal` is 1, all 16 bits of the live word read 1.
- R8: Outside thermal shutdown, bits 7 to 12 read 0.
- R9: `test_en[i]` is 1 exactly when diagnosis is active and output i is off.
- R10: In `SNAP_IDLE`, a `frame_start` high at a clock edge loads `snap_word` with the live word and enters `SNAP_HOLD`. In `SNAP_HOLD`, `snap_word` holds and further `frame_start` pulses are ignored until `frame_end` returns the machine to `SNAP_IDLE`.
- R11: After reset, `snap_word` is 0 and the machine is in `SNAP_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| sw_on | input | NOUT | switch state per output, 1 = on |
| ol_hit | input | NOUT | open-load comparator per output, 1 = open load |
| ol_en_n | input | 1 | diagnosis enable, 0 = enabled |
| sw_run | input | 1 | software run bit, 0 = standby |
| hw_run | input | 1 | hardware run pin, 0 = standby |
| warn | input | 1 | temperature prewarning flag |
| short_flag | input | 1 | short-circuit flag |
| supply_fail | input | 1 | supply-fail flag |
| thermal | input | 1 | thermal shutdown latch |
| frame_start | input | 1 | start-of-frame pulse |
| frame_end | input | 1 | end-of-frame pulse |
| live_word | output | 16 | combinational status word |
| snap_word | output | 16 | status word captured at frame start |
| test_en | output | NOUT | open-load test current enable per output |

## Verification
The bench builds the block with the default of six outputs. With six outputs, every per-output bit from 1 to 6 can be walked one at a time, and the unused field 7 to 12 has its full width to check against zero. This width also lets every diagnosis mode be set up: the enable alone, software inhibit, hardware inhibit and thermal override. Each mode is combined with mixed switch and comparator patterns. The capture machine is driven through repeated starts inside a frame, so the ignored-restart path is reached.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int WORD_W      = 16;
    localparam int POS_WARN    = 0;
    localparam int POS_CH_BASE = 1;
    localparam int POS_SHORT   = 13;
    localparam int POS_STBY    = 14;
    localparam int POS_SUPPLY  = 15;

    typedef enum logic [0:0] {
        SNAP_IDLE = 1'b0,
        SNAP_HOLD = 1'b1
    } snap_state_e;
endpackage

// File: rtl/dds_chan.sv
module dds_chan (
    input  logic on,
    input  logic ol_hit,
    input  logic diag_act,
    output logic stat_bit,
    output logic probe_en
);
    // test current flows only into an off output under active diagnosis
    assign probe_en = diag_act & ~on;
    // on dominates; otherwise the comparator is visible only while testing
    assign stat_bit = on | (diag_act & ol_hit);
endmodule

// File: rtl/dds_assemble.sv
module dds_assemble
    import dds_pkg::*;
#(
    parameter int NOUT = 6
) (
    input  logic [NOUT-1:0]   chan_bits,
    input  logic              warn,
    input  logic              short_flag,
    input  logic              supply_fail,
    input  logic              sw_run,
    input  logic              hw_run,
    input  logic              thermal,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = '0;
        if (thermal) begin
            word = '1;
        end else begin
            word[POS_WARN]               = warn;
            word[POS_CH_BASE +: NOUT]    = chan_bits;
            word[POS_SHORT]              = short_flag;
            word[POS_STBY]               = ~sw_run | ~hw_run;
            word[POS_SUPPLY]             = supply_fail;
        end
    end
endmodule

// File: rtl/dds_snap_fsm.sv
module dds_snap_fsm
    import dds_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic [WORD_W-1:0] live_word,
    output logic [WORD_W-1:0] snap_word,
    output logic              in_frame
);
    snap_state_e state_q, state_d;
    logic        cap_en;
    logic [WORD_W-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_IDLE: if (frame_start) state_d = SNAP_HOLD;
            SNAP_HOLD: if (frame_end)   state_d = SNAP_IDLE;
            default:                    state_d = SNAP_IDLE;
        endcase
    end

    always_comb begin
        cap_en   = 1'b0;
        in_frame = 1'b0;
        unique case (state_q)
            SNAP_IDLE: cap_en   = frame_start;
            SNAP_HOLD: in_frame = 1'b1;
            default:   cap_en   = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      snap_q <= '0;
        else if (cap_en) snap_q <= live_word;
    end

    assign snap_word = snap_q;
endmodule

// File: rtl/drv_diag_status.sv
module drv_diag_status
    import dds_pkg::*;
#(
    parameter int NOUT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NOUT-1:0]   sw_on,
    input  logic [NOUT-1:0]   ol_hit,
    input  logic              ol_en_n,
    input  logic              sw_run,
    input  logic              hw_run,
    input  logic              warn,
    input  logic              short_flag,
    input  logic              supply_fail,
    input  logic              thermal,
    input  logic              frame_start,
    input  logic              frame_end,
    output logic [WORD_W-1:0] live_word,
    output logic [WORD_W-1:0] snap_word,
    output logic [NOUT-1:0]   test_en
);
    logic            diag_act;
    logic [NOUT-1:0] chan_bits;
    logic            in_frame;

    assign diag_act = ~ol_en_n & sw_run;

    for (genvar i = 0; i < NOUT; i++) begin : g_chan
        dds_chan u_chan (
            .on       (sw_on[i]),
            .ol_hit   (ol_hit[i]),
            .diag_act (diag_act),
            .stat_bit (chan_bits[i]),
            .probe_en (test_en[i])
        );
    end

    dds_assemble #(.NOUT(NOUT)) u_asm (
        .chan_bits   (chan_bits),
        .warn        (warn),
        .short_flag  (short_flag),
        .supply_fail (supply_fail),
        .sw_run      (sw_run),
        .hw_run      (hw_run),
        .thermal     (thermal),
        .word        (live_word)
    );

    dds_snap_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .live_word   (live_word),
        .snap_word   (snap_word),
        .in_frame    (in_frame)
    );
endmodule

// File: rtl/drv_diag_status_chk.sv
module drv_diag_status_chk #(
    parameter int NOUT = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NOUT-1:0] sw_on,
    input logic [NOUT-1:0] test_en,
    input logic            hw_run,
    input logic            thermal,
    input logic            frame_start,
    input logic            frame_end,
    input logic [15:0]     live_word,
    input logic [15:0]     snap_word,
    input logic            in_frame
);
    // R9
    test_off_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en & sw_on) == '0);
    // R7
    thermal_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thermal |-> (live_word == 16'hFFFF));
    // R6
    hw_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_run |-> live_word[14]);
    // R8
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !thermal |-> (live_word[12:7] == 6'd0));
    // R10
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && frame_start) |=> (snap_word == $past(live_word)));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !frame_end) |=> ($stable(snap_word) && in_frame));
endmodule

bind drv_diag_status drv_diag_status_chk #(.NOUT(NOUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_on       (sw_on),
    .test_en     (test_en),
    .hw_run      (hw_run),
    .thermal     (thermal),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .live_word   (live_word),
    .snap_word   (snap_word),
    .in_frame    (in_frame)
);

// File: tb/drv_diag_status_tb_top.sv
`timescale 1ns/1ps
module drv_diag_status_tb_top;
    localparam int NOUT = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NOUT-1:0] sw_on, ol_hit;
    logic            ol_en_n, sw_run, hw_run, warn, short_flag, supply_fail, thermal;
    logic            frame_start, frame_end;
    logic [15:0]     live_word, snap_word;
    logic [NOUT-1:0] test_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    drv_diag_status #(.NOUT(NOUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .ol_hit(ol_hit),
        .ol_en_n(ol_en_n), .sw_run(sw_run), .hw_run(hw_run), .warn(warn),
        .short_flag(short_flag), .supply_fail(supply_fail), .thermal(thermal),
        .frame_start(frame_start), .frame_end(frame_end),
        .live_word(live_word), .snap_word(snap_word), .test_en(test_en)
    );

    task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk6(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sw_on = '0; ol_hit = '0; ol_en_n = 1'b1; sw_run = 1'b1; hw_run = 1'b1;
        warn = 0; short_flag = 0; supply_fail = 0; thermal = 0;
        frame_start = 0; frame_end = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk16("R11 snap after reset", snap_word, 16'h0000);
        chk16("R8 quiet live word", live_word, 16'h0000);
    endtask

    task automatic t_fixed_bits();
        @(negedge clk); idle_inputs(); warn = 1; #1;
        chk16("R1 prewarn bit0", live_word, 16'h0001);
        warn = 0; short_flag = 1; #1;
        chk16("R1 short bit13", live_word, 16'h2000);
        short_flag = 0; supply_fail = 1; #1;
        chk16("R1 supply bit15", live_word, 16'h8000);
    endtask

    task automatic t_order();
        @(negedge clk); idle_inputs();
        for (int i = 0; i < NOUT; i++) begin
            sw_on = 6'(1 << i); #1;
            chk16("R2 output order", live_word, 16'(1 << (i + 1)));
        end
    endtask

    task automatic t_openload();
        @(negedge clk); idle_inputs(); ol_en_n = 0; ol_hit = 6'b101001; #1;
        chk16("R3 off outputs show comparator", live_word, 16'h0052);
        chk6("R9 all off under test", test_en, 6'h3F);
        sw_on = 6'b000001; ol_hit = 6'b000000; #1;
        chk16("R3 on output shows on", live_word, 16'h0002);
        chk6("R9 on output not probed", test_en, 6'b111110);
    endtask

    task automatic t_diag_disabled();
        @(negedge clk); idle_inputs(); ol_en_n = 1; ol_hit = 6'h3F; #1;
        chk16("R4 comparator ignored", live_word, 16'h0000);
        chk6("R9 no probe when disabled", test_en, 6'h00);
    endtask

    task automatic t_sw_inhibit();
        @(negedge clk); idle_inputs(); ol_en_n = 0; sw_run = 0; ol_hit = 6'h3F; #1;
        chk16("R5 sw inhibit kills diagnosis", live_word, 16'h4000);
        chk6("R5 no probe in sw inhibit", test_en, 6'h00);
    endtask

    task automatic t_hw_inhibit();
        @(negedge clk); idle_inputs(); ol_en_n = 0; hw_run = 0; ol_hit = 6'h3F; #1;
        chk16("R6 hw inhibit sets bit14", live_word, 16'h407E);
        chk6("R6 hw inhibit keeps probe", test_en, 6'h3F);
    endtask

    task automatic t_thermal();
        @(negedge clk); idle_inputs(); thermal = 1; #1;
        chk16("R7 thermal all ones", live_word, 16'hFFFF);
        thermal = 0; warn = 1; short_flag = 1; supply_fail = 1; sw_on = 6'h3F;
        sw_run = 0; hw_run = 0; #1;
        chk16("R8 unused field zero", live_word, 16'hE07F);
    endtask

    task automatic t_snapshot();
        @(negedge clk); idle_inputs(); warn = 1; frame_start = 1;
        settle(); frame_start = 0;
        chk16("R10 capture at start", snap_word, 16'h0001);
        warn = 0; short_flag = 1; frame_start = 1;
        settle(); frame_start = 0;
        chk16("R10 restart ignored in frame", snap_word, 16'h0001);
        frame_end = 1;
        settle(); frame_end = 0;
        chk16("R10 held through end", snap_word, 16'h0001);
        frame_start = 1;
        settle(); frame_start = 0;
        chk16("R10 new frame recaptures", snap_word, 16'h2000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_fixed_bits();
        t_order();
        t_openload();
        t_diag_disabled();
        t_sw_inhibit();
        t_hw_inhibit();
        t_thermal();
        t_snapshot();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule